// File: doc/BRIEF.md
# Security interrupt status aggregator

This block gathers the level-sensitive interrupt status lines of a chip's security checkers into a small set of 32-bit registers that software reads through a simple word-wide register port. There are three families of sources: memory protection checkers (internal and expansion), peripheral protection controllers (two internal APB ones, four APB expansion ones and four AHB expansion ones), and expansion master security controllers. Each family's status lines land at fixed bit positions in that family's status register.

Software clears and enables interrupts at the sources themselves. A write to the peripheral clear register sends each peripheral controller a one-cycle clear pulse taken from its own bit of the current status; no local bit is cleared. A write to the controller-family clear register sends pulses from the written value. A peripheral enable register drives a per-controller enable line. Only the controller family feeds a combined interrupt output, gated by its own enable register. A bridge error enable register is kept for software, but bridge status always reads zero.

Top module: `sec_irq_collector`

## Requirements
- R1: Word address 0 reads the memory-checker status: internal checker input n appears at bit n and expansion checker input n at bit n+16, one clock after the input changes; all other bits read 0.
- R2: Word address 1 reads the peripheral-controller status: internal APB controllers at bits 0 and 1, APB expansion controllers 0..3 at bits 4..7, AHB expansion controllers 0..3 at bits 20..23, one clock after the input; all other bits read 0.
- R3: Word address 3 is the peripheral enable register; a write keeps only the bits under mask 0x00F000F3, and one clock later each controller's enable output equals its bit (same positions as R2).
- R4: A write to word address 2 makes each peripheral controller's clear output a one-cycle pulse equal to its bit of the status register at the time of the write; the status register is unchanged and address 2 reads 0. Without such a write all clear outputs are 0.
- R5: Word address 4 reads the controller-family status, with expansion input n at bit n+16; the combined interrupt output is high exactly when the status and controller enable registers share a set bit.
- R6: A write to word address 5 drives controller clear output i for one cycle with bit i+16 of the written value; address 5 reads 0 and without such a write the clear outputs are 0.
- R7: Word address 6 is the controller enable register; a write keeps only bits 16 up to 16+NUM_EXP_CTL-1.
- R8: Word address 9 is the bridge enable register and keeps only bits 31..16; word address 7 (bridge status) always reads 0, and a write to word address 8 (bridge clear) changes no register and no output.
- R9: After reset every register reads 0 and every enable, clear and interrupt output is 0.
- R10: Writes to the read-only status addresses 0, 1, 4 and 7 and to unmapped addresses 10..15 change nothing; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | AW | Word address of the register port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| chk_int_stat | input | NUM_INT_CHK | Internal memory-checker status lines |
| chk_exp_stat | input | NUM_EXP_CHK | Expansion memory-checker status lines |
| apb_int_stat | input | 2 | Internal APB peripheral controller status |
| apb_exp_stat | input | 4 | APB expansion peripheral controller status |
| ahb_exp_stat | input | 4 | AHB expansion peripheral controller status |
| apb_int_clr | output | 2 | Clear pulses to internal APB controllers |
| apb_int_en | output | 2 | Enables to internal APB controllers |
| apb_exp_clr | output | 4 | Clear pulses to APB expansion controllers |
| apb_exp_en | output | 4 | Enables to APB expansion controllers |
| ahb_exp_clr | output | 4 | Clear pulses to AHB expansion controllers |
| ahb_exp_en | output | 4 | Enables to AHB expansion controllers |
| ctl_exp_stat | input | NUM_EXP_CTL | Expansion master security controller status |
| ctl_exp_clr | output | NUM_EXP_CTL | Clear pulses to expansion controllers |
| ctl_irq | output | 1 | Combined controller-family interrupt |

## Verification
Random status patterns on all source lines, paired with a random write to any of the sixteen addresses, distinguish a misplaced status bit (wrong offset in R1, R2, R5) from a wrong write mask (R3, R7, R8), since every register is read back after each step. Clear writes issued while the peripheral status is random show whether pulses carry the status bits rather than the written data, and a check on the following cycle separates a one-cycle pulse from a held level. Directed cases cover the reset state, a bridge clear that must not disturb the bridge enable, and a controller clear with a sparse known value.

// File: rtl/sec_irq_collector.sv
module sec_irq_collector #(
  parameter int NUM_INT_CHK = 2,
  parameter int NUM_EXP_CHK = 4,
  parameter int NUM_EXP_CTL = 4,
  parameter int AW          = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic [NUM_INT_CHK-1:0] chk_int_stat,
  input  logic [NUM_EXP_CHK-1:0] chk_exp_stat,
  input  logic [1:0]             apb_int_stat,
  input  logic [3:0]             apb_exp_stat,
  input  logic [3:0]             ahb_exp_stat,
  output logic [1:0]             apb_int_clr,
  output logic [1:0]             apb_int_en,
  output logic [3:0]             apb_exp_clr,
  output logic [3:0]             apb_exp_en,
  output logic [3:0]             ahb_exp_clr,
  output logic [3:0]             ahb_exp_en,
  input  logic [NUM_EXP_CTL-1:0] ctl_exp_stat,
  output logic [NUM_EXP_CTL-1:0] ctl_exp_clr,
  output logic                   ctl_irq
);

  localparam logic [AW-1:0] A_CHK_STAT = AW'(0);
  localparam logic [AW-1:0] A_PPC_STAT = AW'(1);
  localparam logic [AW-1:0] A_PPC_CLR  = AW'(2);
  localparam logic [AW-1:0] A_PPC_EN   = AW'(3);
  localparam logic [AW-1:0] A_CTL_STAT = AW'(4);
  localparam logic [AW-1:0] A_CTL_EN   = AW'(6);
  localparam logic [AW-1:0] A_CTL_CLR  = AW'(5);
  localparam logic [AW-1:0] A_BRG_STAT = AW'(7);
  localparam logic [AW-1:0] A_BRG_EN   = AW'(9);

  localparam logic [31:0] PPC_MASK = 32'h00F0_00F3;
  localparam logic [31:0] CTL_MASK = 32'(((64'd1 << NUM_EXP_CTL) - 64'd1) << 16);
  localparam logic [31:0] BRG_MASK = 32'hFFFF_0000;

  logic [31:0] chk_d, ppc_d, ctl_d;
  logic [31:0] chk_q, ppc_q, ctl_q;
  logic [31:0] ppc_en_q, ctl_en_q, brg_en_q, ppc_clr_q;
  logic [NUM_EXP_CTL-1:0] ctl_clr_q;

  always_comb begin
    chk_d = '0;
    chk_d[NUM_INT_CHK-1:0]   = chk_int_stat;
    chk_d[16 +: NUM_EXP_CHK] = chk_exp_stat;
    ppc_d = '0;
    ppc_d[1:0]   = apb_int_stat;
    ppc_d[7:4]   = apb_exp_stat;
    ppc_d[23:20] = ahb_exp_stat;
    ctl_d = '0;
    ctl_d[16 +: NUM_EXP_CTL] = ctl_exp_stat;
  end

  wire wr_ppc_clr = wr_en && addr == A_PPC_CLR;
  wire wr_ctl_clr = wr_en && addr == A_CTL_CLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q     <= '0;
      ppc_q     <= '0;
      ctl_q     <= '0;
      ppc_en_q  <= '0;
      ctl_en_q  <= '0;
      brg_en_q  <= '0;
      ppc_clr_q <= '0;
      ctl_clr_q <= '0;
    end else begin
      chk_q     <= chk_d;
      ppc_q     <= ppc_d;
      ctl_q     <= ctl_d;
      ppc_clr_q <= wr_ppc_clr ? ppc_q : '0;
      ctl_clr_q <= wr_ctl_clr ? wdata[16 +: NUM_EXP_CTL] : '0;
      if (wr_en && addr == A_PPC_EN) ppc_en_q <= wdata & PPC_MASK;
      if (wr_en && addr == A_CTL_EN) ctl_en_q <= wdata & CTL_MASK;
      if (wr_en && addr == A_BRG_EN) brg_en_q <= wdata & BRG_MASK;
    end
  end

  assign apb_int_en  = ppc_en_q[1:0];
  assign apb_exp_en  = ppc_en_q[7:4];
  assign ahb_exp_en  = ppc_en_q[23:20];
  assign apb_int_clr = ppc_clr_q[1:0];
  assign apb_exp_clr = ppc_clr_q[7:4];
  assign ahb_exp_clr = ppc_clr_q[23:20];
  assign ctl_exp_clr = ctl_clr_q;
  assign ctl_irq     = |(ctl_q & ctl_en_q);

  always_comb begin
    case (addr)
      A_CHK_STAT: rdata = chk_q;
      A_PPC_STAT: rdata = ppc_q;
      A_PPC_EN:   rdata = ppc_en_q;
      A_CTL_STAT: rdata = ctl_q;
      A_CTL_EN:   rdata = ctl_en_q;
      A_BRG_STAT: rdata = '0;
      A_BRG_EN:   rdata = brg_en_q;
      default:    rdata = '0;
    endcase
  end

endmodule

module sec_irq_collector_chk #(
  parameter int NUM_EXP_CTL = 4,
  parameter int AW          = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          addr,
  input logic [31:0]            wdata,
  input logic [1:0]             apb_int_clr,
  input logic [1:0]             apb_int_en,
  input logic [3:0]             apb_exp_clr,
  input logic [3:0]             apb_exp_en,
  input logic [3:0]             ahb_exp_clr,
  input logic [3:0]             ahb_exp_en,
  input logic [NUM_EXP_CTL-1:0] ctl_exp_stat,
  input logic [NUM_EXP_CTL-1:0] ctl_exp_clr,
  input logic                   ctl_irq
);

  p_en_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> (apb_int_en == $past(wdata[1:0]) &&
      apb_exp_en == $past(wdata[7:4]) && ahb_exp_en == $past(wdata[23:20])))
    else $error("p_en_follow_r3");

  p_clr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|{apb_int_clr, apb_exp_clr, ahb_exp_clr}) |-> $past(wr_en && addr == AW'(2)))
    else $error("p_clr_cause_r4");

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_irq |-> $past(|ctl_exp_stat))
    else $error("p_irq_source_r5");

  p_ctl_clr_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(5)) |=> ctl_exp_clr == $past(wdata[16 +: NUM_EXP_CTL]))
    else $error("p_ctl_clr_data_r6");

  p_ctl_clr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(5)) |=> ctl_exp_clr == '0)
    else $error("p_ctl_clr_idle_r6");

endmodule

bind sec_irq_collector sec_irq_collector_chk #(.NUM_EXP_CTL(NUM_EXP_CTL), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .apb_int_clr(apb_int_clr), .apb_int_en(apb_int_en),
  .apb_exp_clr(apb_exp_clr), .apb_exp_en(apb_exp_en),
  .ahb_exp_clr(ahb_exp_clr), .ahb_exp_en(ahb_exp_en),
  .ctl_exp_stat(ctl_exp_stat), .ctl_exp_clr(ctl_exp_clr), .ctl_irq(ctl_irq)
);

// File: tb/test_sec_irq_collector.sv
`timescale 1ns/1ps
module test_sec_irq_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] ci = '0;
  logic [3:0] ce = '0, ai = '0, ae = '0, he = '0, cx = '0;
  logic [1:0] ai2;
  logic [1:0] apb_int_clr, apb_int_en;
  logic [3:0] apb_exp_clr, apb_exp_en, ahb_exp_clr, ahb_exp_en, ctl_exp_clr;
  logic ctl_irq;
  int nchk = 0, nfail = 0;
  logic [31:0] ppc_en_m = '0, ctl_en_m = '0, brg_en_m = '0;

  always #5 clk = ~clk;
  assign ai2 = ai[1:0];

  sec_irq_collector i_sec_irq_collector (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .chk_int_stat(ci), .chk_exp_stat(ce), .apb_int_stat(ai2), .apb_exp_stat(ae),
    .ahb_exp_stat(he), .apb_int_clr(apb_int_clr), .apb_int_en(apb_int_en),
    .apb_exp_clr(apb_exp_clr), .apb_exp_en(apb_exp_en), .ahb_exp_clr(ahb_exp_clr),
    .ahb_exp_en(ahb_exp_en), .ctl_exp_stat(cx), .ctl_exp_clr(ctl_exp_clr), .ctl_irq(ctl_irq)
  );

  function automatic logic [31:0] chk_exp();
    return {12'd0, ce, 14'd0, ci};
  endfunction
  function automatic logic [31:0] ppc_exp();
    return {8'd0, he, 12'd0, ae, 2'd0, ai2};
  endfunction
  function automatic logic [31:0] ctl_exp();
    return {12'd0, cx, 16'd0};
  endfunction
  function automatic logic [31:0] ppc_out(input logic [1:0] a, input logic [3:0] b, input logic [3:0] c);
    return {8'd0, c, 12'd0, b, 2'd0, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    rd(4'd0, d);  check({tag, " R1 chk stat"}, d, chk_exp());
    rd(4'd1, d);  check({tag, " R2 ppc stat"}, d, ppc_exp());
    rd(4'd2, d);  check({tag, " R4 ppc clr reads 0"}, d, 32'h0);
    rd(4'd3, d);  check({tag, " R3 ppc en"}, d, ppc_en_m);
    rd(4'd4, d);  check({tag, " R5 ctl stat"}, d, ctl_exp());
    rd(4'd5, d);  check({tag, " R6 ctl clr reads 0"}, d, 32'h0);
    rd(4'd6, d);  check({tag, " R7 ctl en"}, d, ctl_en_m);
    rd(4'd7, d);  check({tag, " R8 brg stat"}, d, 32'h0);
    rd(4'd9, d);  check({tag, " R8 brg en"}, d, brg_en_m);
    for (int a = 10; a < 16; a++) begin
      rd(4'(a), d); check({tag, " R10 unmapped"}, d, 32'h0);
    end
    check({tag, " R3 en outputs"}, ppc_out(apb_int_en, apb_exp_en, ahb_exp_en), ppc_en_m);
    check({tag, " R5 irq"}, {31'd0, ctl_irq}, {31'd0, |(ctl_exp() & ctl_en_m)});
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      4'd3: ppc_en_m = d & 32'h00F0_00F3;
      4'd6: ctl_en_m = d & 32'h000F_0000;
      4'd9: brg_en_m = d & 32'hFFFF_0000;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] exp_pclr;
    logic [3:0]  exp_cclr;
    logic [3:0]  wa;
    logic [31:0] wd;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_regs("reset R9");
    check("R9 clr outputs", ppc_out(apb_int_clr, apb_exp_clr, ahb_exp_clr), 32'h0);
    check("R9 ctl clr", {28'd0, ctl_exp_clr}, 32'h0);

    do_write(4'd9, 32'h1234_5678);
    check_regs("dir R8 brg en mask");
    do_write(4'd8, 32'hFFFF_FFFF);
    check_regs("dir R8 brg clr no effect");
    check("R8 brg clr no clear pulse", ppc_out(apb_int_clr, apb_exp_clr, ahb_exp_clr), 32'h0);
    do_write(4'd5, 32'h000A_0000);
    check("dir R6 ctl clr pulse", {28'd0, ctl_exp_clr}, 32'hA);
    @(posedge clk); @(negedge clk);
    check("dir R6 ctl clr one cycle", {28'd0, ctl_exp_clr}, 32'h0);
    do_write(4'd15, 32'hFFFF_FFFF);
    check_regs("dir R10 unmapped write");

    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      ci = 2'($urandom); ce = 4'($urandom); ai = 4'($urandom);
      ae = 4'($urandom); he = 4'($urandom); cx = 4'($urandom);
      @(posedge clk);
      wa = ($urandom_range(0, 3) == 0) ? 4'd2 : 4'($urandom_range(0, 15));
      wd = $urandom;
      exp_pclr = (wa == 4'd2) ? ppc_exp() : 32'h0;
      exp_cclr = (wa == 4'd5) ? wd[19:16] : 4'h0;
      do_write(wa, wd);
      check("R4 ppc clr pulse", ppc_out(apb_int_clr, apb_exp_clr, ahb_exp_clr), exp_pclr);
      check("R6 ctl clr pulse", {28'd0, ctl_exp_clr}, {28'd0, exp_cclr});
      check_regs("rand");
      @(posedge clk); @(negedge clk);
      check("R4 ppc clr one cycle", ppc_out(apb_int_clr, apb_exp_clr, ahb_exp_clr), 32'h0);
      check("R6 ctl clr idle", {28'd0, ctl_exp_clr}, 32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule